// File: doc/BRIEF.md
# Waveform Grid Renderer

This block draws a timing diagram of a captured sample buffer on a 640x480 raster. A video timing generator supplies the current pixel column and line. The renderer splits the screen into square cells of 16 pixels. Inside a rectangular region of that cell grid, each cell stands for one bit of one captured word. A cell column picks the sample word and a cell row picks the signal (bit). The stored level is drawn as a flat line across the full cell width: high levels sit on the cell's middle line and low levels sit on its bottom line.

The renderer drives a read address into an external capture RAM. That RAM has one cycle of read latency. The renderer pipelines the pixel decision so that the returned word lines up with the coordinate that asked for it. The pixel output therefore lags the coordinate inputs by a fixed three clock cycles, and the sync path must be delayed by the same amount. Pixels outside the grid, pixels on any other line of a cell, and every pixel while the enable is low all produce background.

Top module: `wgrid_waveform_render`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `pixelOn` is 0 and `ramRdAddr` is 0.
- R2: A cell is 2^CELL_LOG2 pixels square (16 by default), and cell indices are pixel coordinates divided by the cell size. The grid covers cell columns GRID_COL0 to GRID_COL0+NUM_WORDS-1 and cell rows GRID_ROW0 to GRID_ROW0+WORD_W-1.
- R3: One clock after a coordinate is presented, `ramRdAddr` equals the cell column minus GRID_COL0 if that column lies inside the grid, and 0 otherwise.
- R4: A pixel in relative cell row r (cell row minus GRID_ROW0) shows bit r of the word read, with bit 0 on the top row of the grid.
- R5: If the selected bit is 1, the pixel is on only on line CELL/2 within its cell (line offset pixY mod CELL), and this holds for every pixel column of the cell.
- R6: If the selected bit is 0, the pixel is on only on the last line of its cell (offset CELL-1), and this holds for every pixel column of the cell.
- R7: No vertical edge is drawn where adjacent samples differ. In the cell-boundary pixel columns, lines other than the two trace lines stay dark.
- R8: Pixels whose cell column or cell row lies outside the grid are dark, whatever the RAM contents.
- R9: The `enable` input is sampled together with the coordinate. A coordinate presented while `enable` is 0 yields a dark pixel.
- R10: `pixelOn` for a coordinate presented before rising edge t is valid after rising edge t+2 (three edges counting t). The output after edges t and t+1 still reflects earlier coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pixX | input | COORD_W | Current pixel column from the timing generator |
| pixY | input | COORD_W | Current pixel line from the timing generator |
| enable | input | 1 | Drawing enabled (capture complete) |
| ramRdAddr | output | ADDR_W | Capture RAM read address (sample word index) |
| ramRdData | input | WORD_W | Capture RAM read data, valid one cycle after the address |
| pixelOn | output | 1 | Trace colour when 1, background when 0 |

## Verification
The bench uses the default parameters: 16-pixel cells, sixteen 16-bit words, and a grid origin at cell column 8 and cell row 6, so the grid spans pixels 128 to 383 by 96 to 351. With these values the bench can reach both grid edges and the pixels just outside them, the middle and bottom trace lines, and the boundary columns between samples. Full-width streaming line sweeps compare every pixel, including blanking-range columns, against a model fed with the same RAM pattern. This checks the three-cycle alignment between the address path and the data path.

// File: rtl/wgrid_pkg.sv
package wgrid_pkg;

  // Strobes handed from the cell decoder to the trace datapath.
  typedef struct packed {
    logic valid;   // coordinate inside grid and drawing enabled
    logic midLine; // line offset equals the middle trace line
    logic botLine; // line offset equals the bottom trace line
  } traceStrobes_t;

endpackage

// File: rtl/wgrid_cell_ctrl.sv
module wgrid_cell_ctrl
  import wgrid_pkg::*;
#(
  parameter int COORD_W   = 10,
  parameter int CELL_LOG2 = 4,
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 16,
  parameter int GRID_COL0 = 8,
  parameter int GRID_ROW0 = 6,
  localparam int ADDR_W   = $clog2(NUM_WORDS),
  localparam int BIT_W    = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic               enable,
  output logic [ADDR_W-1:0]  ramRdAddr,
  output logic [BIT_W-1:0]   bitIdx,
  output traceStrobes_t      strobes
);

  localparam int IDX_W    = COORD_W - CELL_LOG2;
  localparam int CELL     = 1 << CELL_LOG2;
  localparam int MID_LINE = CELL / 2;
  localparam int BOT_LINE = CELL - 1;

  logic [IDX_W-1:0]     cellCol;
  logic [IDX_W-1:0]     cellRow;
  logic [CELL_LOG2-1:0] lineOfs;
  logic                 colInGrid;
  logic                 rowInGrid;
  logic [IDX_W-1:0]     relCol;
  logic [IDX_W-1:0]     relRow;
  traceStrobes_t        nextStrobes;

  always_comb begin
    cellCol   = pixX[COORD_W-1:CELL_LOG2];
    cellRow   = pixY[COORD_W-1:CELL_LOG2];
    lineOfs   = pixY[CELL_LOG2-1:0];
    colInGrid = (int'(cellCol) >= GRID_COL0) && (int'(cellCol) < GRID_COL0 + NUM_WORDS);
    rowInGrid = (int'(cellRow) >= GRID_ROW0) && (int'(cellRow) < GRID_ROW0 + WORD_W);
    relCol    = cellCol - IDX_W'(GRID_COL0);
    relRow    = cellRow - IDX_W'(GRID_ROW0);
    nextStrobes.valid   = enable && colInGrid && rowInGrid;
    nextStrobes.midLine = (int'(lineOfs) == MID_LINE);
    nextStrobes.botLine = (int'(lineOfs) == BOT_LINE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramRdAddr <= '0;
      bitIdx    <= '0;
      strobes   <= '0;
    end else begin
      ramRdAddr <= colInGrid ? relCol[ADDR_W-1:0] : '0;
      bitIdx    <= rowInGrid ? relRow[BIT_W-1:0] : '0;
      strobes   <= nextStrobes;
    end
  end

endmodule

// File: rtl/wgrid_trace_path.sv
module wgrid_trace_path
  import wgrid_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BIT_W-1:0]  bitIdx,
  input  traceStrobes_t     strobes,
  input  logic [WORD_W-1:0] ramRdData,
  output logic              pixelOn
);

  // Second stage waits for the RAM's one-cycle read.
  logic [BIT_W-1:0] s2BitIdx;
  traceStrobes_t    s2Strobes;
  logic             levelBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2BitIdx  <= '0;
      s2Strobes <= '0;
      pixelOn   <= 1'b0;
    end else begin
      s2BitIdx  <= bitIdx;
      s2Strobes <= strobes;
      pixelOn   <= s2Strobes.valid &&
                   (levelBit ? s2Strobes.midLine : s2Strobes.botLine);
    end
  end

  always_comb levelBit = ramRdData[s2BitIdx];

endmodule

// File: rtl/wgrid_waveform_render.sv
module wgrid_waveform_render
  import wgrid_pkg::*;
#(
  parameter int COORD_W   = 10,
  parameter int CELL_LOG2 = 4,
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 16,
  parameter int GRID_COL0 = 8,
  parameter int GRID_ROW0 = 6,
  localparam int ADDR_W   = $clog2(NUM_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic               enable,
  output logic [ADDR_W-1:0]  ramRdAddr,
  input  logic [WORD_W-1:0]  ramRdData,
  output logic               pixelOn
);

  localparam int BIT_W = $clog2(WORD_W);

  logic [BIT_W-1:0] bitIdx;
  traceStrobes_t    strobes;

  wgrid_cell_ctrl #(
    .COORD_W(COORD_W), .CELL_LOG2(CELL_LOG2), .NUM_WORDS(NUM_WORDS),
    .WORD_W(WORD_W), .GRID_COL0(GRID_COL0), .GRID_ROW0(GRID_ROW0)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pixX(pixX), .pixY(pixY), .enable(enable),
    .ramRdAddr(ramRdAddr), .bitIdx(bitIdx), .strobes(strobes)
  );

  wgrid_trace_path #(.WORD_W(WORD_W)) u_path (
    .clk(clk), .rstN(rstN), .bitIdx(bitIdx), .strobes(strobes),
    .ramRdData(ramRdData), .pixelOn(pixelOn)
  );

endmodule

// File: rtl/wgrid_render_checker.sv
module wgrid_render_checker #(
  parameter int COORD_W   = 10,
  parameter int CELL_LOG2 = 4,
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 16,
  parameter int GRID_COL0 = 8,
  parameter int GRID_ROW0 = 6,
  localparam int ADDR_W   = $clog2(NUM_WORDS)
) (
  input logic               clk,
  input logic               rstN,
  input logic [COORD_W-1:0] pixX,
  input logic [COORD_W-1:0] pixY,
  input logic               enable,
  input logic [ADDR_W-1:0]  ramRdAddr,
  input logic               pixelOn
);

  localparam int CELL = 1 << CELL_LOG2;

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  function automatic logic colIn(input logic [COORD_W-1:0] x);
    return (int'(x) / CELL >= GRID_COL0) && (int'(x) / CELL < GRID_COL0 + NUM_WORDS);
  endfunction

  function automatic logic rowIn(input logic [COORD_W-1:0] y);
    return (int'(y) / CELL >= GRID_ROW0) && (int'(y) / CELL < GRID_ROW0 + WORD_W);
  endfunction

  // R3: address follows the cell column one cycle later
  p_addr_track_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0) |->
      (int'(ramRdAddr) == (colIn($past(pixX)) ? int'($past(pixX)) / CELL - GRID_COL0 : 0)));

  // R9: disabled coordinate gives a dark pixel three cycles later
  p_dark_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && !$past(enable, 3)) |-> !pixelOn);

  // R8: outside the grid nothing is drawn
  p_dark_outside_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && !(colIn($past(pixX, 3)) && rowIn($past(pixY, 3)))) |-> !pixelOn);

  // R5/R6/R7: a lit pixel is always on one of the two trace lines
  p_trace_lines_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && pixelOn) |->
      ((int'($past(pixY, 3)) % CELL == CELL / 2) || (int'($past(pixY, 3)) % CELL == CELL - 1)));

  // R1: outputs idle on the first cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0) |-> (!pixelOn && ramRdAddr == '0));

endmodule

bind wgrid_waveform_render wgrid_render_checker #(
  .COORD_W(COORD_W), .CELL_LOG2(CELL_LOG2), .NUM_WORDS(NUM_WORDS),
  .WORD_W(WORD_W), .GRID_COL0(GRID_COL0), .GRID_ROW0(GRID_ROW0)
) u_checker (
  .clk(clk), .rstN(rstN), .pixX(pixX), .pixY(pixY), .enable(enable),
  .ramRdAddr(ramRdAddr), .pixelOn(pixelOn)
);

// File: tb/tb_wgrid_waveform_render.sv
`timescale 1ns/1ps
module tb_wgrid_waveform_render;

  localparam int CELL = 16;
  localparam int COL0 = 8;
  localparam int ROW0 = 6;
  localparam int NW   = 16;
  localparam int WW   = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  pixX = '0;
  logic [9:0]  pixY = '0;
  logic        enable = 1'b0;
  logic [3:0]  ramRdAddr;
  logic [15:0] ramRdData;
  logic        pixelOn;
  logic [15:0] mem [NW];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) ramRdData <= mem[ramRdAddr];

  wgrid_waveform_render dut (
    .clk(clk), .rstN(rstN), .pixX(pixX), .pixY(pixY), .enable(enable),
    .ramRdAddr(ramRdAddr), .ramRdData(ramRdData), .pixelOn(pixelOn)
  );

  function automatic logic expPix(int x, int y, logic en);
    int cc = x / CELL;
    int cr = y / CELL;
    int ofs = y % CELL;
    logic b;
    if (!en || cc < COL0 || cc >= COL0 + NW || cr < ROW0 || cr >= ROW0 + WW) return 1'b0;
    b = mem[cc - COL0][cr - ROW0];
    return b ? (ofs == CELL / 2) : (ofs == CELL - 1);
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < NW; i++) mem[i] = '0;
  endtask

  task automatic checkPix(string req, int x, int y, logic en);
    @(negedge clk);
    pixX = 10'(x); pixY = 10'(y); enable = en;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req, int'(pixelOn), int'(expPix(x, y, en)));
  endtask

  task automatic scanLine(string req, int y, logic en);
    logic h0 = 1'b0, h1 = 1'b0, h2 = 1'b0;
    for (int x = 0; x < 800 + 3; x++) begin
      @(negedge clk);
      if (x >= 3) chk(req, int'(pixelOn), int'(h2));
      h2 = h1; h1 = h0;
      h0 = (x < 800) ? expPix(x, y, en) : 1'b0;
      pixX = 10'(x < 800 ? x : 0); pixY = 10'(y); enable = en;
    end
  endtask

  task automatic t_reset();
    chk("R1 pixelOn in reset", int'(pixelOn), 0);
    chk("R1 ramRdAddr in reset", int'(ramRdAddr), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 pixelOn after release", int'(pixelOn), 0);
  endtask

  task automatic t_address();
    @(negedge clk); pixX = 10'((COL0 + 5) * CELL + 3); pixY = 10'(ROW0 * CELL);
    @(posedge clk); @(negedge clk);
    chk("R3 address inside grid", int'(ramRdAddr), 5);
    pixX = 10'((COL0 + NW - 1) * CELL + 15);
    @(posedge clk); @(negedge clk);
    chk("R3 address last column", int'(ramRdAddr), NW - 1);
    pixX = 10'((COL0 + NW) * CELL);
    @(posedge clk); @(negedge clk);
    chk("R3 address outside grid", int'(ramRdAddr), 0);
  endtask

  task automatic t_high_low();
    clearMem();
    mem[3] = 16'h0004;
    checkPix("R5 high on middle line", (COL0 + 3) * CELL + 4, (ROW0 + 2) * CELL + 8, 1'b1);
    checkPix("R5 high not on line above", (COL0 + 3) * CELL + 4, (ROW0 + 2) * CELL + 7, 1'b1);
    checkPix("R5 high not on bottom line", (COL0 + 3) * CELL + 4, (ROW0 + 2) * CELL + 15, 1'b1);
    checkPix("R6 low on bottom line", (COL0 + 3) * CELL + 9, ROW0 * CELL + 15, 1'b1);
    checkPix("R6 low not on middle line", (COL0 + 3) * CELL + 9, ROW0 * CELL + 8, 1'b1);
  endtask

  task automatic t_bit_rows();
    clearMem();
    mem[0] = 16'h8001;
    checkPix("R4 bit0 on top grid row", COL0 * CELL, ROW0 * CELL + 8, 1'b1);
    checkPix("R4 bit15 on last grid row", COL0 * CELL, (ROW0 + 15) * CELL + 8, 1'b1);
    checkPix("R4 bit1 low row", COL0 * CELL, (ROW0 + 1) * CELL + 15, 1'b1);
    scanLine("R4 R2 sweep bit15 row", (ROW0 + 15) * CELL + 8, 1'b1);
  endtask

  task automatic t_edges();
    clearMem();
    mem[4] = 16'hFFFF;
    mem[5] = 16'h0000;
    for (int y = 9; y < 15; y++)
      checkPix("R7 no vertical edge at boundary", (COL0 + 5) * CELL, (ROW0 + 3) * CELL + y, 1'b1);
    checkPix("R7 high side last column", (COL0 + 5) * CELL - 1, (ROW0 + 3) * CELL + 8, 1'b1);
    checkPix("R7 low side first column", (COL0 + 5) * CELL, (ROW0 + 3) * CELL + 15, 1'b1);
  endtask

  task automatic t_outside();
    for (int i = 0; i < NW; i++) mem[i] = 16'hA5C3;
    checkPix("R8 left of grid", COL0 * CELL - 1, (ROW0 + 4) * CELL + 8, 1'b1);
    checkPix("R8 right of grid", (COL0 + NW) * CELL, (ROW0 + 4) * CELL + 15, 1'b1);
    checkPix("R8 above grid", (COL0 + 2) * CELL, ROW0 * CELL - 1, 1'b1);
    checkPix("R8 below grid", (COL0 + 2) * CELL, (ROW0 + WW) * CELL + 8, 1'b1);
    scanLine("R8 R2 sweep middle lines", (ROW0 + 7) * CELL + 8, 1'b1);
    scanLine("R8 R2 sweep bottom lines", (ROW0 + 10) * CELL + 15, 1'b1);
  endtask

  task automatic t_disable();
    for (int i = 0; i < NW; i++) mem[i] = 16'hFFFF;
    checkPix("R9 enabled reference", (COL0 + 1) * CELL, ROW0 * CELL + 8, 1'b1);
    checkPix("R9 disabled dark", (COL0 + 1) * CELL, ROW0 * CELL + 8, 1'b0);
    scanLine("R9 sweep disabled", (ROW0 + 5) * CELL + 8, 1'b0);
  endtask

  task automatic t_latency();
    clearMem();
    @(negedge clk);
    pixX = 10'(COL0 * CELL); pixY = 10'(ROW0 * CELL + 8); enable = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 miss settled", int'(pixelOn), 0);
    pixY = 10'(ROW0 * CELL + 15);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 not yet after two edges", int'(pixelOn), 0);
    @(posedge clk); @(negedge clk);
    chk("R10 valid after third edge", int'(pixelOn), 1);
  endtask

  initial begin
    clearMem();
    repeat (3) @(posedge clk);
    t_reset();
    t_address();
    t_high_low();
    t_bit_rows();
    t_edges();
    t_outside();
    t_disable();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule